// File: doc/BRIEF.md
# Flash Command Interface with Program/Erase Suspend

This block is a behavioural model of the command front end of a NOR-style flash array. A host writes commands by pulsing `we_i` for one clock with a command code in the low byte of `wdata_i` and an address on `addr_i`. The block decodes each command. It runs word program and block erase as timed busy operations whose length comes from a parameter. The host can suspend and resume either operation. The block also keeps a sticky status word and a read mode that stays in force until a command changes it.

The array is a small internal memory of `2**ADDR_W` 16-bit words, split into blocks of `2**BLK_W` words. A program operation can only clear bits. An erase sets every word of the selected block to all ones. Both changes are committed to the array only when the operation's timer finishes. Block lock decisions are made outside the block and arrive on `blk_locked_i`, which is sampled when the data word or the confirm code is written. The read port is combinational: `rdata_o` returns array data, identifier data or the status word, depending on the current read mode.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After `rst_ni` is released, the read mode is array and the status word is 0x0080.
- R2: Code 0x40 or 0x10, followed by a data write at a word address, starts a program operation. The status word reads bit 7 = 0 for PROG_CYCLES cycles. The stored word then becomes the old word ANDed with the written data.
- R3: Status bit layout: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 2 program suspended, bit 1 lock error. All other bits read 0.
- R4: The read mode persists until changed. Code 0xFF selects array reads. Code 0x90 or 0x98 selects identifier reads: address offset 0 gives 0x00A5, offset 1 gives 0x5A31, offset 2 gives the lock flag in bit 0. Code 0x70 selects the status word, whatever the address. Program setup, erase setup, suspend and resume also switch the read mode to status.
- R5: Code 0x20 followed by 0xD0 at an address inside a block erases that block. After ERASE_CYCLES cycles every word of that block reads 0xFFFF, and the other blocks keep their contents.
- R6: If code 0x20 is followed by any code other than 0xD0, status bits 4 and 5 are set, nothing is erased, and the block returns to idle.
- R7: Error bits 5, 4 and 1 stay set across later operations. Only code 0x50, written while idle, clears them.
- R8: Code 0xB0 during a program operation sets bit 2 and bit 7 on the next cycle. Code 0xD0 then resumes the program, which clears bits 2 and 7, and the program completes with the remaining cycles.
- R9: While a program is suspended, only codes 0x70, 0x90, 0x98 and 0xD0 act. Any other code leaves both the state and the read mode unchanged.
- R10: Code 0xB0 during an erase sets bits 6 and 7. While the erase is suspended, array and identifier reads work, and a program may run in another block, after which the block returns to erase-suspended. Code 0xD0 resumes the erase, which then completes.
- R11: During an erase suspend, a program aimed at the block being erased sets bit 4 and leaves the array unchanged.
- R12: If `blk_locked_i` is high when the program data or the erase confirm is written, the operation does not start. Bit 1 is set, together with bit 4 for a program or bit 5 for an erase, and the array is unchanged.
- R13: Asserting `rst_ni` during a program aborts it: the target word keeps its old contents and the status word returns to 0x0080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe, one command or data word per cycle |
| addr_i | input | ADDR_W | Word address for writes and reads |
| wdata_i | input | 16 | Command code (low byte) or program data |
| blk_locked_i | input | 1 | Lock flag for the block addressed by the current write |
| rdata_o | output | 16 | Read data according to the current read mode |

## Verification
The assertions assume that `we_i` is a single-cycle strobe. They also assume that `wdata_i` and `blk_locked_i` hold steady for the cycle in which `we_i` is sampled, and that the lock flag describes the block on `addr_i` at that moment. The bench drives every write and lock change on the falling clock edge and lowers `we_i` one cycle later. It raises `blk_locked_i` only around the single data or confirm write that it is meant to block. It never sends a suspend after a timer could already have expired, so each suspend lands while its operation is still running.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rmode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PSETUP, ST_ESETUP, ST_PRUN, ST_ERUN,
    ST_PSUSP, ST_ESUSP, ST_ES_PSETUP, ST_ES_PRUN
  } fstate_e;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_ID    = 8'h90;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_RD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;

  localparam int unsigned SB_READY = 7;
  localparam int unsigned SB_ESUSP = 6;
  localparam int unsigned SB_EERR  = 5;
  localparam int unsigned SB_PERR  = 4;
  localparam int unsigned SB_PSUSP = 2;
  localparam int unsigned SB_LERR  = 1;
endpackage

// File: rtl/fc_timer.sv
module fc_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign done_o = act_q & run_i & (cnt_q == '0);

  // count holds while run_i is low (suspend)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(CYCLES - 1);
      act_q <= 1'b1;
    end else if (act_q && run_i) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fc_array.sv
module fc_array #(
  parameter int unsigned AW = 6,
  parameter int unsigned BW = 4,
  parameter int unsigned DW = 16
) (
  input  logic             clk_i,
  input  logic             prog_i,
  input  logic [AW-1:0]    prog_addr_i,
  input  logic [DW-1:0]    prog_data_i,
  input  logic             erase_i,
  input  logic [AW-BW-1:0] erase_blk_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [DW-1:0]    rd_data_o
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i) begin
    for (int w = 0; w < WORDS; w++) begin
      if (erase_i && ((AW'(w) >> BW) == AW'(erase_blk_i)))
        mem_q[w] <= '1;
      else if (prog_i && (AW'(w) == prog_addr_i))
        mem_q[w] <= mem_q[w] & prog_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned BLK_W        = 4,
  parameter int unsigned PROG_CYCLES  = 6,
  parameter int unsigned ERASE_CYCLES = 30,
  parameter logic [15:0] MFR_CODE     = 16'h00A5,
  parameter logic [15:0] DEV_CODE     = 16'h5A31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              blk_locked_i,
  output logic [15:0]       rdata_o
);
  localparam int unsigned NB_W = ADDR_W - BLK_W;

  fstate_e st_q, st_d;
  rmode_e  mode_q, mode_d;
  logic    err_p_q, err_p_d, err_e_q, err_e_d, err_l_q, err_l_d;
  logic    prog_start, erase_start, prog_done, erase_done;
  logic    prog_run, erase_run, busy, psusp, esusp;
  logic [ADDR_W-1:0] paddr_q;
  logic [15:0]       pdata_q, arr_data, id_data, status_w;
  logic [NB_W-1:0]   eblk_q;
  logic [7:0]        cmd;
  logic [NB_W-1:0]   blk_in;

  assign cmd    = wdata_i[7:0];
  assign blk_in = addr_i[ADDR_W-1:BLK_W];

  always_comb begin
    st_d        = st_q;
    mode_d      = mode_q;
    err_p_d     = err_p_q;
    err_e_d     = err_e_q;
    err_l_d     = err_l_q;
    prog_start  = 1'b0;
    erase_start = 1'b0;
    unique case (st_q)
      ST_IDLE: if (we_i) begin
        case (cmd)
          CMD_RD_ARRAY:           mode_d = RM_ARRAY;
          CMD_RD_ID, CMD_QUERY:   mode_d = RM_IDENT;
          CMD_RD_STAT:            mode_d = RM_STATUS;
          CMD_CLR_STAT: begin
            err_p_d = 1'b0;
            err_e_d = 1'b0;
            err_l_d = 1'b0;
          end
          CMD_PROG, CMD_PROG_ALT: begin
            st_d   = ST_PSETUP;
            mode_d = RM_STATUS;
          end
          CMD_ERASE: begin
            st_d   = ST_ESETUP;
            mode_d = RM_STATUS;
          end
          default: ;
        endcase
      end
      ST_PSETUP: if (we_i) begin
        if (blk_locked_i) begin
          err_p_d = 1'b1;
          err_l_d = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          prog_start = 1'b1;
          st_d       = ST_PRUN;
        end
      end
      ST_ESETUP: if (we_i) begin
        st_d = ST_IDLE;
        if (cmd != CMD_CONFIRM) begin
          err_p_d = 1'b1;
          err_e_d = 1'b1;
        end else if (blk_locked_i) begin
          err_e_d = 1'b1;
          err_l_d = 1'b1;
        end else begin
          erase_start = 1'b1;
          st_d        = ST_ERUN;
        end
      end
      ST_PRUN: begin
        if (prog_done)                         st_d = ST_IDLE;
        else if (we_i && cmd == CMD_SUSPEND)   st_d = ST_PSUSP;
      end
      ST_ERUN: begin
        if (erase_done)                        st_d = ST_IDLE;
        else if (we_i && cmd == CMD_SUSPEND)   st_d = ST_ESUSP;
      end
      ST_PSUSP: if (we_i) begin
        case (cmd)
          CMD_RD_STAT:          mode_d = RM_STATUS;
          CMD_RD_ID, CMD_QUERY: mode_d = RM_IDENT;
          CMD_CONFIRM: begin
            st_d   = ST_PRUN;
            mode_d = RM_STATUS;
          end
          default: ;
        endcase
      end
      ST_ESUSP: if (we_i) begin
        case (cmd)
          CMD_RD_ARRAY:         mode_d = RM_ARRAY;
          CMD_RD_STAT:          mode_d = RM_STATUS;
          CMD_RD_ID, CMD_QUERY: mode_d = RM_IDENT;
          CMD_PROG, CMD_PROG_ALT: begin
            st_d   = ST_ES_PSETUP;
            mode_d = RM_STATUS;
          end
          CMD_CONFIRM: begin
            st_d   = ST_ERUN;
            mode_d = RM_STATUS;
          end
          default: ;
        endcase
      end
      ST_ES_PSETUP: if (we_i) begin
        st_d = ST_ESUSP;
        if (blk_in == eblk_q) begin
          err_p_d = 1'b1;
        end else if (blk_locked_i) begin
          err_p_d = 1'b1;
          err_l_d = 1'b1;
        end else begin
          prog_start = 1'b1;
          st_d       = ST_ES_PRUN;
        end
      end
      ST_ES_PRUN: if (prog_done) st_d = ST_ESUSP;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= RM_ARRAY;
      err_p_q <= 1'b0;
      err_e_q <= 1'b0;
      err_l_q <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
      eblk_q  <= '0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      err_p_q <= err_p_d;
      err_e_q <= err_e_d;
      err_l_q <= err_l_d;
      if (prog_start) begin
        paddr_q <= addr_i;
        pdata_q <= wdata_i;
      end
      if (erase_start) eblk_q <= blk_in;
    end
  end

  assign prog_run  = (st_q == ST_PRUN) || (st_q == ST_ES_PRUN);
  assign erase_run = (st_q == ST_ERUN);
  assign busy      = prog_run || erase_run;
  assign psusp     = (st_q == ST_PSUSP);
  assign esusp     = (st_q == ST_ESUSP) || (st_q == ST_ES_PSETUP) || (st_q == ST_ES_PRUN);

  fc_timer #(.CYCLES(PROG_CYCLES)) u_prog_tmr (
    .clk_i, .rst_ni, .start_i(prog_start), .run_i(prog_run), .done_o(prog_done)
  );

  fc_timer #(.CYCLES(ERASE_CYCLES)) u_erase_tmr (
    .clk_i, .rst_ni, .start_i(erase_start), .run_i(erase_run), .done_o(erase_done)
  );

  fc_array #(.AW(ADDR_W), .BW(BLK_W), .DW(16)) u_array (
    .clk_i,
    .prog_i      (prog_done),
    .prog_addr_i (paddr_q),
    .prog_data_i (pdata_q),
    .erase_i     (erase_done),
    .erase_blk_i (eblk_q),
    .rd_addr_i   (addr_i),
    .rd_data_o   (arr_data)
  );

  always_comb begin
    status_w           = '0;
    status_w[SB_READY] = ~busy;
    status_w[SB_ESUSP] = esusp;
    status_w[SB_EERR]  = err_e_q;
    status_w[SB_PERR]  = err_p_q;
    status_w[SB_PSUSP] = psusp;
    status_w[SB_LERR]  = err_l_q;
  end

  always_comb begin
    case (addr_i[1:0])
      2'd0:    id_data = MFR_CODE;
      2'd1:    id_data = DEV_CODE;
      2'd2:    id_data = {15'd0, blk_locked_i};
      default: id_data = '0;
    endcase
  end

  always_comb begin
    case (mode_q)
      RM_ARRAY: rdata_o = arr_data;
      RM_IDENT: rdata_o = id_data;
      default:  rdata_o = status_w;
    endcase
  end
endmodule

// File: rtl/fc_checker.sv
module fc_checker
  import fc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [7:0]  cmd_i,
  input logic        blk_locked_i,
  input fstate_e     st_i,
  input rmode_e      mode_i,
  input logic [15:0] status_i
);
  a_r2_prog_goes_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PSETUP && we_i && !blk_locked_i) |=> !status_i[SB_READY]);

  a_r8_suspend_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PRUN && we_i && cmd_i == CMD_SUSPEND) |=> status_i[SB_READY]);

  a_r8_resume_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PSUSP && we_i && cmd_i == CMD_CONFIRM)
      |=> (!status_i[SB_READY] && !status_i[SB_PSUSP]));

  a_r9_psusp_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_PSUSP && we_i && cmd_i == CMD_RD_ARRAY)
      |=> (st_i == ST_PSUSP && $stable(mode_i)));

  a_r6_seq_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_ESETUP && we_i && cmd_i != CMD_CONFIRM)
      |=> (status_i[SB_EERR] && status_i[SB_PERR]));

  a_r7_error_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[SB_EERR] && !(we_i && cmd_i == CMD_CLR_STAT)) |=> status_i[SB_EERR]);

  a_r3_one_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({status_i[SB_PSUSP], status_i[SB_ESUSP]}));
endmodule

bind flash_cmd_ctrl fc_checker u_fc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .we_i         (we_i),
  .cmd_i        (wdata_i[7:0]),
  .blk_locked_i (blk_locked_i),
  .st_i         (st_q),
  .mode_i       (mode_q),
  .status_i     (status_w)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int WD_CYCLES = 50000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   wdata_i = '0;
  logic          blk_locked_i = 1'b0;
  logic [15:0]   rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  flash_cmd_ctrl dut_i (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .blk_locked_i, .rdata_o
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i  = a;
    wdata_i = d;
    we_i    = 1'b1;
    @(negedge clk_i);
    we_i    = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_ready();
    logic [15:0] s;
    for (int i = 0; i < 500; i++) begin
      rd('0, s);
      if (s[7]) break;
      @(negedge clk_i);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] s;
    do_reset();
    wr('0, 16'h0070);
    rd(6'h09, s);
    check("R1 reset status", s, 16'h0080);
    for (int b = 0; b < 4; b++) begin
      wr(AW'(b << 4), 16'h0020);
      wr(AW'(b << 4), 16'h00D0);
      wait_ready();
    end
    wr('0, 16'h00FF);
    rd(6'h1F, s);
    check("R5 initial erase", s, 16'hFFFF);
  endtask

  task automatic t_program();
    logic [15:0] s;
    wr(6'h03, 16'h0040);
    wr(6'h03, 16'h12F0);
    rd('0, s);
    check("R2 busy after data", s, 16'h0000);
    wait_ready();
    rd(6'h2A, s);
    check("R3 ready after program", s, 16'h0080);
    wr('0, 16'h00FF);
    rd(6'h03, s);
    check("R2 programmed word", s, 16'h12F0);
    wr(6'h03, 16'h0010);
    wr(6'h03, 16'hFF0F);
    wait_ready();
    wr('0, 16'h00FF);
    rd(6'h03, s);
    check("R2 AND with old data", s, 16'h1200);
    repeat (3) @(negedge clk_i);
    rd(6'h04, s);
    check("R4 array mode persists", s, 16'hFFFF);
  endtask

  task automatic t_ident();
    logic [15:0] s;
    wr('0, 16'h0090);
    rd(6'h00, s);
    check("R4 ident offset 0", s, 16'h00A5);
    rd(6'h01, s);
    check("R4 ident offset 1", s, 16'h5A31);
    blk_locked_i = 1'b1;
    rd(6'h02, s);
    check("R4 ident lock flag", s, 16'h0001);
    blk_locked_i = 1'b0;
    wr('0, 16'h0070);
    rd(6'h3D, s);
    check("R4 status any address", s, 16'h0080);
  endtask

  task automatic t_seq_err();
    logic [15:0] s;
    wr(6'h10, 16'h0020);
    wr(6'h10, 16'h00FF);
    rd('0, s);
    check("R6 sequence error", s, 16'h00B0);
    wr(6'h06, 16'h0040);
    wr(6'h06, 16'h0F0F);
    wait_ready();
    rd('0, s);
    check("R7 error sticky", s, 16'h00B0);
    wr('0, 16'h0050);
    rd('0, s);
    check("R7 clear status", s, 16'h0080);
    wr('0, 16'h00FF);
    rd(6'h10, s);
    check("R6 nothing erased", s, 16'hFFFF);
  endtask

  task automatic t_lock();
    logic [15:0] s;
    wr(6'h05, 16'h0040);
    blk_locked_i = 1'b1;
    wr(6'h05, 16'h0000);
    blk_locked_i = 1'b0;
    rd('0, s);
    check("R12 locked program", s, 16'h0092);
    wr('0, 16'h00FF);
    rd(6'h05, s);
    check("R12 array unchanged", s, 16'hFFFF);
    wr('0, 16'h0050);
    wr(6'h10, 16'h0020);
    blk_locked_i = 1'b1;
    wr(6'h10, 16'h00D0);
    blk_locked_i = 1'b0;
    rd('0, s);
    check("R12 locked erase", s, 16'h00A2);
    wr('0, 16'h0050);
    rd('0, s);
    check("R7 clear after lock", s, 16'h0080);
  endtask

  task automatic t_psusp();
    logic [15:0] s;
    wr(6'h07, 16'h0040);
    wr(6'h07, 16'h00FF);
    wr('0, 16'h00B0);
    rd('0, s);
    check("R8 program suspended", s, 16'h0084);
    wr('0, 16'h00FF);
    rd(6'h07, s);
    check("R9 read array ignored", s, 16'h0084);
    wr('0, 16'h0020);
    rd('0, s);
    check("R9 erase setup ignored", s, 16'h0084);
    wr('0, 16'h0090);
    rd(6'h00, s);
    check("R9 ident accepted", s, 16'h00A5);
    wr('0, 16'h00D0);
    rd('0, s);
    check("R8 resume clears 7 and 2", s, 16'h0000);
    wait_ready();
    wr('0, 16'h00FF);
    rd(6'h07, s);
    check("R8 resumed program done", s, 16'h00FF);
  endtask

  task automatic t_esusp();
    logic [15:0] s;
    wr(6'h21, 16'h0040);
    wr(6'h21, 16'h0000);
    wait_ready();
    wr(6'h20, 16'h0020);
    wr(6'h20, 16'h00D0);
    wr('0, 16'h00B0);
    rd('0, s);
    check("R10 erase suspended", s, 16'h00C0);
    wr('0, 16'h00FF);
    rd(6'h21, s);
    check("R10 erase not finished", s, 16'h0000);
    wr(6'h12, 16'h0040);
    wr(6'h12, 16'hAAAA);
    rd('0, s);
    check("R10 program in suspend busy", s, 16'h0040);
    wait_ready();
    rd('0, s);
    check("R10 back to erase suspend", s, 16'h00C0);
    wr(6'h25, 16'h0040);
    wr(6'h25, 16'h0000);
    rd('0, s);
    check("R11 same block rejected", s, 16'h00D0);
    wr('0, 16'h00FF);
    rd(6'h25, s);
    check("R11 array unchanged", s, 16'hFFFF);
    rd(6'h12, s);
    check("R10 other block programmed", s, 16'hAAAA);
    wr('0, 16'h00D0);
    wait_ready();
    wr('0, 16'h00FF);
    rd(6'h21, s);
    check("R5 erase completed", s, 16'hFFFF);
    rd(6'h12, s);
    check("R5 other block kept", s, 16'hAAAA);
    wr('0, 16'h0070);
    rd('0, s);
    check("R7 error kept after erase", s, 16'h0090);
    wr('0, 16'h0050);
  endtask

  task automatic t_abort();
    logic [15:0] s;
    wr(6'h30, 16'h0040);
    wr(6'h30, 16'h0000);
    do_reset();
    rd(6'h30, s);
    check("R13 aborted word unchanged", s, 16'hFFFF);
    wr('0, 16'h0070);
    rd('0, s);
    check("R13 status after abort", s, 16'h0080);
  endtask

  initial begin
    t_reset();
    t_program();
    t_ident();
    t_seq_err();
    t_lock();
    t_psusp();
    t_esusp();
    t_abort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule